// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits between a processor's three active-low status lines and the system bus. The processor presents a 3-bit code for each bus cycle. The block decodes that code and drives active-low command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. For each of the two write types it also drives an advanced strobe, which asserts one clock earlier than the ordinary one. The block also supplies three per-cycle control signals: address latch enable, data enable and data direction.

A bus cycle opens on the first clock edge at which the status lines hold any code other than passive (111). The code sampled on that edge is stored, and the cycle follows the stored code until the lines return to passive. A fixed three-step sequence shapes every cycle. First comes an address phase, in which the latch enable pulses. Next comes a lead phase, which turns on read, acknowledge and advanced write strobes. Last comes a full phase, which also turns on the ordinary write strobes. The block has no data stream, so every pin is a plain level signal with no handshake.

Top module: `bus_cmd_gen`

## Requirements
- R1: Stored status codes map to commands as follows. 000 drives interrupt acknowledge. 001 drives I/O read. 010 drives I/O write. 100 (instruction fetch) and 101 (memory read) both drive memory read. 110 drives memory write. 011 is halt and 111 is passive.
- R2: Let the first edge at which the status lines hold a non-passive code be E0. The latch enable is high from E0 until E0+1 and is low at all other times.
- R3: For read, fetch, I/O read and acknowledge codes, the command asserts (goes low) at E0+1. The advanced write strobes also assert at E0+1 for codes 110 and 010.
- R4: The ordinary write strobes assert at E0+2, one clock after their advanced strobe, and never without it.
- R5: A halt code (011) opens a cycle and pulses latch enable, but it drives no command and leaves data enable low.
- R6: The direction output is low (receive) from E0 until the cycle ends for codes 000, 001, 100 and 101. It is high (transmit) at all other times, including write and halt cycles.
- R7: Data enable is high exactly while some command strobe is asserted.
- R8: On the edge at which the status lines are sampled as 111, every command goes inactive, data enable drops and direction returns high. A new cycle may open on the next edge.
- R9: While reset is held, all commands are high, latch enable and data enable are low, and direction is high.
- R10: A change of the status lines to another non-passive code in mid-cycle has no effect. The commands keep following the code stored at E0.
- R11: If the status lines return to 111 during the address phase, the cycle ends with no command asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_st_n | input | 3 | Processor status code, active low, 111 = passive |
| bus_ale | output | 1 | Address latch enable pulse |
| bus_dir | output | 1 | Data direction, 1 = transmit, 0 = receive |
| bus_den | output | 1 | Data enable, active high |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_awr_n | output | 1 | Advanced memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_awr_n | output | 1 | Advanced I/O write command |
| int_ack_n | output | 1 | Interrupt acknowledge command |

## Verification
The assertions check the following on every cycle:
- latch enable never stays high for two clocks;
- at most one command group is active at once;
- every ordinary write is preceded by its advanced strobe;
- a passive sample ends all commands on the next edge;
- the sequencer opens a cycle correctly out of idle.

Only the bench scenarios can show the rest. This covers the full decode table against the stored code, the exact edges at which each strobe asserts, the direction level for each cycle type, the immunity to mid-cycle code changes and the aborted cycle that never reaches a command.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STW = 3;

  localparam logic [STW-1:0] ST_INTA    = 3'b000;
  localparam logic [STW-1:0] ST_IORD    = 3'b001;
  localparam logic [STW-1:0] ST_IOWR    = 3'b010;
  localparam logic [STW-1:0] ST_HALT    = 3'b011;
  localparam logic [STW-1:0] ST_FETCH   = 3'b100;
  localparam logic [STW-1:0] ST_MEMRD   = 3'b101;
  localparam logic [STW-1:0] ST_MEMWR   = 3'b110;
  localparam logic [STW-1:0] ST_PASSIVE = 3'b111;

  // number of write channels that carry an advanced strobe (memory, I/O)
  localparam int NWR = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_LEAD = 2'd2,
    PH_FULL = 2'd3
  } phase_t;

  typedef struct packed {
    logic           inta;
    logic           iord;
    logic           mrd;
    logic [NWR-1:0] wr;    // [0] memory write, [1] I/O write
    logic           recv;
  } kind_t;
endpackage

// File: rtl/status_decode.sv
module status_decode
  import bus_cmd_pkg::*;
(
  input  logic [STW-1:0] code,
  output kind_t          kind
);
  always_comb begin
    kind = '0;
    unique case (code)
      ST_INTA:  begin kind.inta  = 1'b1; kind.recv = 1'b1; end
      ST_IORD:  begin kind.iord  = 1'b1; kind.recv = 1'b1; end
      ST_IOWR:  kind.wr[1] = 1'b1;
      ST_FETCH,
      ST_MEMRD: begin kind.mrd   = 1'b1; kind.recv = 1'b1; end
      ST_MEMWR: kind.wr[0] = 1'b1;
      default:  kind = '0;   // halt and passive: no command
    endcase
  end
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import bus_cmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] st_n,
  output phase_t         phase,
  output logic [STW-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      code_q <= ST_PASSIVE;
    end else if (st_n == ST_PASSIVE) begin
      phase  <= PH_IDLE;
      code_q <= ST_PASSIVE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase  <= PH_ADDR;
          code_q <= st_n;
        end
        PH_ADDR: phase <= PH_LEAD;
        default: phase <= PH_FULL;
      endcase
    end
  end

  // R2
  open_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && st_n != ST_PASSIVE) |=> (phase == PH_ADDR && code_q == $past(st_n)));

  // R8
  close_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_n == ST_PASSIVE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/strobe_drive.sv
module strobe_drive
  import bus_cmd_pkg::*;
(
  input  phase_t         phase,
  input  kind_t          kind,
  output logic           ale,
  output logic           dir,
  output logic           den,
  output logic           mrd_n,
  output logic           iord_n,
  output logic           inta_n,
  output logic [NWR-1:0] awr_n,
  output logic [NWR-1:0] wr_n
);
  logic           lead_on;
  logic           full_on;
  logic [NWR-1:0] adv_act;

  assign lead_on = (phase == PH_LEAD) || (phase == PH_FULL);
  assign full_on = (phase == PH_FULL);

  genvar g;
  generate
    for (g = 0; g < NWR; g++) begin : g_wr
      assign adv_act[g] = lead_on & kind.wr[g];
      assign awr_n[g]   = ~adv_act[g];
      assign wr_n[g]    = ~(full_on & kind.wr[g]);
    end
  endgenerate

  assign ale    = (phase == PH_ADDR);
  assign mrd_n  = ~(lead_on & kind.mrd);
  assign iord_n = ~(lead_on & kind.iord);
  assign inta_n = ~(lead_on & kind.inta);
  assign den    = (lead_on & (kind.mrd | kind.iord | kind.inta)) | (|adv_act);
  assign dir    = ~((phase != PH_IDLE) & kind.recv);
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] cpu_st_n,
  output logic           bus_ale,
  output logic           bus_dir,
  output logic           bus_den,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           mem_awr_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  output logic           io_awr_n,
  output logic           int_ack_n
);
  phase_t         phase;
  logic [STW-1:0] code_q;
  kind_t          kind;
  logic [NWR-1:0] awr_n;
  logic [NWR-1:0] wr_n;

  cycle_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_n   (cpu_st_n),
    .phase  (phase),
    .code_q (code_q)
  );

  status_decode u_dec (
    .code (code_q),
    .kind (kind)
  );

  strobe_drive u_drv (
    .phase  (phase),
    .kind   (kind),
    .ale    (bus_ale),
    .dir    (bus_dir),
    .den    (bus_den),
    .mrd_n  (mem_rd_n),
    .iord_n (io_rd_n),
    .inta_n (int_ack_n),
    .awr_n  (awr_n),
    .wr_n   (wr_n)
  );

  assign mem_awr_n = awr_n[0];
  assign mem_wr_n  = wr_n[0];
  assign io_awr_n  = awr_n[1];
  assign io_wr_n   = wr_n[1];

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  // R1
  one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_rd_n, ~io_rd_n, ~int_ack_n, ~mem_awr_n, ~io_awr_n}));

  // R4
  mem_adv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(!mem_awr_n));

  // R4
  io_adv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_wr_n) |-> $past(!io_awr_n));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_st_n == ST_PASSIVE) |=> (&{mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n,
                                    io_wr_n, io_awr_n, int_ack_n} && !bus_den));

  // R6
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_awr_n || !io_awr_n) |-> bus_dir);
endmodule

// File: tb/sim_bus_cmd_gen.sv
module sim_bus_cmd_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] st_n = 3'b111;
  logic bus_ale, bus_dir, bus_den, mem_rd_n, mem_wr_n, mem_awr_n;
  logic io_rd_n, io_wr_n, io_awr_n, int_ack_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model: phase 0 idle, 1 address, 2 lead, 3 full
  int         m_ph = 0;
  logic [2:0] m_code = 3'b111;

  always #2 clk = ~clk;

  bus_cmd_gen u0 (
    .clk(clk), .rst_n(rst_n), .cpu_st_n(st_n),
    .bus_ale(bus_ale), .bus_dir(bus_dir), .bus_den(bus_den),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n),
    .int_ack_n(int_ack_n)
  );

  // order: ale dir den mrd mwr amwr iord iowr aiowr inta
  function automatic logic [9:0] expect_vec(int ph, logic [2:0] c);
    logic recv, lead, full, mrd, iord, inta, mw, iw;
    recv = (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
    lead = (ph >= 2);
    full = (ph == 3);
    mrd  = lead && (c == 3'b100 || c == 3'b101);
    iord = lead && (c == 3'b001);
    inta = lead && (c == 3'b000);
    mw   = (c == 3'b110);
    iw   = (c == 3'b010);
    return {ph == 1, !(ph != 0 && recv),
            mrd || iord || inta || (lead && (mw || iw)),
            !mrd, !(full && mw), !(lead && mw), !iord,
            !(full && iw), !(lead && iw), !inta};
  endfunction

  function automatic string auto_tag(int ph, logic [2:0] c);
    if (ph == 0) return "R8";
    if (ph == 1) return "R2";
    if (c == 3'b011) return "R5";
    if (ph == 3 && (c == 3'b110 || c == 3'b010)) return "R4";
    if (ph == 2) return "R3";
    return "R1";
  endfunction

  task automatic check_now(string tag);
    logic [9:0] act, exp;
    string t;
    act = {bus_ale, bus_dir, bus_den, mem_rd_n, mem_wr_n, mem_awr_n,
           io_rd_n, io_wr_n, io_awr_n, int_ack_n};
    exp = expect_vec(m_ph, m_code);
    t = (tag == "") ? auto_tag(m_ph, m_code) : tag;
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs act=%b exp=%b (phase %0d code %b)", t, act, exp, m_ph, m_code);
    end
    if (m_ph != 0) begin
      n_chk++;
      if (bus_dir !== exp[8]) begin
        n_bad++;
        $display("FAIL R6: dir act=%b exp=%b", bus_dir, exp[8]);
      end
      n_chk++;
      if (bus_den !== exp[7]) begin
        n_bad++;
        $display("FAIL R7: den act=%b exp=%b", bus_den, exp[7]);
      end
    end
  endtask

  // called just after a falling edge: check, then drive the next status
  task automatic step(logic [2:0] s, string tag);
    check_now(tag);
    st_n = s;
    if (s == 3'b111) begin
      m_ph = 0; m_code = 3'b111;
    end else if (m_ph == 0) begin
      m_ph = 1; m_code = s;
    end else if (m_ph < 3) begin
      m_ph = m_ph + 1;
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_now("R9");   // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 directed pass over every code
    for (int c = 0; c < 7; c++) begin
      for (int k = 0; k < 4; k++) step(3'(c), "");
      step(3'b111, "");
    end
    step(3'b111, "R8");

    // R11 abort during address phase
    step(3'b110, "");
    step(3'b111, "R11");
    step(3'b111, "R11");

    // R10 mid-cycle code change ignored
    step(3'b101, "");
    step(3'b101, "");
    step(3'b110, "R10");
    step(3'b010, "R10");
    step(3'b000, "R10");
    step(3'b111, "R10");

    // R8 back-to-back cycles with a single passive gap
    step(3'b010, "");
    step(3'b010, "");
    step(3'b010, "");
    step(3'b111, "R8");
    step(3'b001, "R8");
    step(3'b001, "");
    step(3'b111, "");

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [2:0] c;
      int hold, gap;
      c = 3'($urandom_range(0, 6));
      hold = int'($urandom_range(1, 6));
      gap = int'($urandom_range(1, 3));
      for (int k = 0; k < hold; k++) begin
        if (k > 0 && $urandom_range(0, 4) == 0)
          step(3'($urandom_range(0, 6)), "R10");
        else
          step(c, "");
      end
      for (int k = 0; k < gap; k++) step(3'b111, "");
    end
    check_now("");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule